// File: doc/BRIEF.md
# Bidirectional Binary Counter with Parallel Load

This block is a synchronous binary counter of parameterizable width (4 bits by default). Each clock it can clear to zero, take a parallel word, or step one count up or down, and it holds its value when none of these is requested. A direction input picks the stepping direction. The counter wraps at both ends of its range.

A terminal-count flag is decoded combinationally from the present value and the direction input. In upward mode the flag marks the top of the range, and in downward mode it marks zero. A parent block uses the flag to build periodic pulses or to reload the counter.

Top module: `udl_counter`

## Requirements
- R1: A synchronous active-high reset `rst` drives the count to zero on the next rising clock edge.
- R2: With `dir_down`=0 and `step_en`=1 (no clear, no load), the count increases by one on each clock edge.
- R3: With `dir_down`=1 and `step_en`=1 (no clear, no load), the count decreases by one on each clock edge.
- R4: Counting up from all ones gives all zeros. Counting down from all zeros gives all ones.
- R5: With `dir_down`=0, `term` is 1 exactly when the count is all ones.
- R6: With `dir_down`=1, `term` is 1 exactly when the count is all zeros.
- R7: When `load`=1 (and no clear), the count takes `load_val` on the next edge, whatever `step_en` and `dir_down` are.
- R8: When `clr`=1, the count becomes zero on the next edge, regardless of `load` and `step_en`.
- R9: With `clr`, `load` and `step_en` all 0, the count holds its value.
- R10: `term` depends only on the count and `dir_down`, and does not depend on `step_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Clear to zero (highest priority) |
| load | input | 1 | Load parallel word (second priority) |
| step_en | input | 1 | Advance the count by one step |
| dir_down | input | 1 | 0 steps up, 1 steps down |
| load_val | input | WIDTH | Parallel word to load |
| count | output | WIDTH | Current count |
| term | output | 1 | Terminal count for the current direction |

## Verification
The bench builds the counter with its default WIDTH of 4. With this width, a full 16-state cycle is short enough to walk in each direction, so the bench can check both wraps and every terminal-count position directly. It also covers every pairing of clear, load and enable to confirm the priority order.

// File: rtl/udl_pkg.sv
package udl_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_STEP  = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } udl_op_e;
endpackage

// File: rtl/udl_stepper.sv
module udl_stepper #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             dir_down,
  output logic [WIDTH-1:0] nxt
);
  function automatic logic [WIDTH-1:0] f_step(input logic [WIDTH-1:0] v, input logic dn);
    logic [WIDTH-1:0] one;
    one = {{(WIDTH-1){1'b0}}, 1'b1};
    return dn ? (v - one) : (v + one);
  endfunction

  assign nxt = f_step(cur, dir_down);
endmodule

// File: rtl/udl_term_detect.sv
module udl_term_detect #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             dir_down,
  output logic             term
);
  logic all_ones, all_zeros;
  assign all_ones  = &cur;
  assign all_zeros = ~|cur;
  assign term = dir_down ? all_zeros : all_ones;
endmodule

// File: rtl/udl_counter.sv
module udl_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             load,
  input  logic             step_en,
  input  logic             dir_down,
  input  logic [WIDTH-1:0] load_val,
  output logic [WIDTH-1:0] count,
  output logic             term
);
  import udl_pkg::*;

  localparam logic [WIDTH-1:0] ZERO = '0;
  localparam logic [WIDTH-1:0] ONES = '1;

  logic [WIDTH-1:0] cnt_q, step_val, next_val;
  udl_op_e          op;
  logic             wr_en;

  udl_stepper #(.WIDTH(WIDTH)) u_step (
    .cur(cnt_q), .dir_down(dir_down), .nxt(step_val)
  );

  udl_term_detect #(.WIDTH(WIDTH)) u_term (
    .cur(cnt_q), .dir_down(dir_down), .term(term)
  );

  always_comb begin
    if (clr)          op = OP_CLEAR;
    else if (load)    op = OP_LOAD;
    else if (step_en) op = OP_STEP;
    else              op = OP_HOLD;
  end

  assign wr_en = (op != OP_HOLD);

  always_comb begin
    unique case (op)
      OP_CLEAR: next_val = ZERO;
      OP_LOAD:  next_val = load_val;
      OP_STEP:  next_val = step_val;
      default:  next_val = cnt_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        cnt_q <= ZERO;
    else if (wr_en) cnt_q <= next_val;
  end

  assign count = cnt_q;

  a_r1_reset_zero: assert property (@(posedge clk) rst |=> (count == ZERO));
  a_r8_clear_zero: assert property (@(posedge clk) disable iff (rst) clr |=> (count == ZERO));
  a_r7_load_takes: assert property (@(posedge clk) disable iff (rst)
    (!clr && load) |=> (count == $past(load_val)));
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load && !step_en) |=> $stable(count));
  a_r2_up: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load && step_en && !dir_down) |=> (count == $past(count) + 1'b1));
  a_r3_down: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load && step_en && dir_down) |=> (count == $past(count) - 1'b1));
  a_r4_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (!clr && !load && step_en && !dir_down && count == ONES) |=> (count == ZERO));
  a_r5_term_up: assert property (@(posedge clk) disable iff (rst)
    !dir_down |-> (term == (count == ONES)));
  a_r6_term_down: assert property (@(posedge clk) disable iff (rst)
    dir_down |-> (term == (count == ZERO)));
endmodule

// File: tb/udl_counter_bench.sv
module udl_counter_bench;
  localparam int W = 4;
  logic clk = 0, rst, clr, load, step_en, dir_down;
  logic [W-1:0] load_val, count;
  logic term;
  int checks = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  udl_counter #(.WIDTH(W)) u_udl_counter (
    .clk(clk), .rst(rst), .clr(clr), .load(load), .step_en(step_en),
    .dir_down(dir_down), .load_val(load_val), .count(count), .term(term)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic drive(input logic c, l, e, d, input logic [W-1:0] v);
    clr = c; load = l; step_en = e; dir_down = d; load_val = v;
    @(posedge clk); #5;
  endtask

  function automatic int exp_term(input int v, input logic dn);
    if (dn) return (v == 0) ? 1 : 0;
    return (v == (1 << W) - 1) ? 1 : 0;
  endfunction

  task automatic t_reset();
    rst = 1; drive(0, 1, 1, 0, 4'd9); rst = 0;
    chk("R1", count, 0);
  endtask

  task automatic t_up();
    int e = 0;
    drive(1, 0, 0, 0, 0);
    for (int i = 0; i < 18; i++) begin
      chk("R5", term, exp_term(e, 0));
      drive(0, 0, 1, 0, 0);
      e = (e + 1) % (1 << W);
      chk(e == 0 ? "R4" : "R2", count, e);
    end
  endtask

  task automatic t_down();
    int e = 0;
    drive(1, 0, 0, 1, 0);
    for (int i = 0; i < 18; i++) begin
      chk("R6", term, exp_term(e, 1));
      drive(0, 0, 1, 1, 0);
      e = (e + (1 << W) - 1) % (1 << W);
      chk(e == (1 << W) - 1 ? "R4" : "R3", count, e);
    end
  endtask

  task automatic t_load();
    drive(0, 1, 1, 0, 4'd11); chk("R7", count, 11);
    drive(0, 1, 0, 1, 4'd3);  chk("R7", count, 3);
    drive(0, 1, 1, 1, 4'd15); chk("R7", count, 15);
  endtask

  task automatic t_clear();
    drive(0, 1, 0, 0, 4'd7);  drive(1, 1, 1, 0, 4'd12); chk("R8", count, 0);
    drive(0, 1, 0, 0, 4'd5);  drive(1, 0, 1, 1, 4'd0);  chk("R8", count, 0);
  endtask

  task automatic t_hold();
    drive(0, 1, 0, 0, 4'd6);
    drive(0, 0, 0, 0, 4'd1); chk("R9", count, 6);
    drive(0, 0, 0, 1, 4'd2); chk("R9", count, 6);
  endtask

  task automatic t_term_enable();
    drive(0, 1, 0, 0, 4'd15);
    step_en = 0; dir_down = 0; #1; chk("R10", term, 1);
    step_en = 1; #1; chk("R10", term, 1);
    dir_down = 1; #1; chk("R10", term, 0);
    drive(0, 1, 0, 1, 4'd0);
    step_en = 0; #1; chk("R10", term, 1);
    step_en = 1; #1; chk("R10", term, 1);
  endtask

  initial begin
    rst = 1; clr = 0; load = 0; step_en = 0; dir_down = 0; load_val = 0;
    t_reset(); t_up(); t_down(); t_load(); t_clear(); t_hold(); t_term_enable();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule